// File: doc/BRIEF.md
# Two-Channel DMA Request Sequencer

This block decides when a two-channel DMA engine should ask for the bus, and for which channel. Each channel is set up through a small write port: an operand size, a transfer mode, the low address bits of source and destination, and a byte count. When a channel is started, its setup is checked first. A bad setup raises an error flag, and the channel does not run.

A running channel turns its external request pin into transfer requests. The pin passes through two flops clocked on the falling edge before the request logic sees it. In cycle-steal mode, each rising edge of the pin asks for one operand. In burst mode, operands keep coming for as long as the pin is held high. An arbiter gives channel 0 precedence and presents one request to a modelled bus unit. Once the bus unit grants the request, that operand cannot be interrupted until the bus unit reports it done. Each completed operand lowers the channel's byte count by the operand size. The channel flags done when the count runs out. The bus cycles, the data packing and the address stepping are handled elsewhere.

Top module: `dma_req_seq`

## Requirements
- R1: While `rst` is high, and after it is released, `xfer_req`, `busy`, `done`, `err` and `irq` are all low.
- R2: With the bus idle, a rising edge on `dreq[i]` for a running channel is seen as `xfer_req` high at the second rising clock edge after the first falling edge that samples it. The pin passes through two falling-edge flops, then the registered arbiter.
- R3: In cycle-steal mode (control bit 1 = 0), `dreq` activity while a channel is not running is ignored. A running channel requests exactly one operand per rising edge of its synchronised `dreq`. A level held high asks for nothing further.
- R4: If `dreq[i]` is already high when a cycle-steal channel is started, an internal request is made. `xfer_req` rises at the rising edge after the one that accepts the start write.
- R5: In burst mode (control bit 1 = 1), a running channel requests operands while its synchronised `dreq` is high. Consecutive operands are separated by exactly one cycle with `xfer_req` low. A `dreq` that is already low at that point stops the run, and the channel stays busy.
- R6: A start (control register at address 0, bit 0 written as 1) sets `err` and leaves the channel idle if the size field (bits 3:2: 0 = byte, 1 = word, 2 = longword) selects word or longword while source bit 0 (bit 4) or destination bit 0 (bit 5) is 1.
- R7: A start also sets `err` and leaves the channel idle if any of these hold: the byte count (address 1) is zero, the count is not a multiple of the operand size in bytes (1, 2 or 4), or the size field is 3. A valid start sets `busy`.
- R8: When several channels are requesting and no operand has been granted, `xfer_ch` selects the lowest-numbered one. A lower-numbered channel that starts requesting before the grant takes the slot.
- R9: After `bus_grant` is sampled with `xfer_req` high, `xfer_req` stays high and `xfer_ch` stays unchanged until `cyc_done` is sampled. In the next cycle `xfer_req` is low.
- R10: Each completed operand lowers the channel's byte count by 1, 2 or 4 as its size selects. The operand that brings the count to zero sets `done` and clears `busy` on the same edge. `xfer_size` shows the size code of the selected channel.
- R11: A write to the status register (address 2) clears `done` where bit 0 is 1 and clears `err` where bit 1 is 1. Bits written as 0 leave the flags alone. `irq[i]` is high whenever `done[i]` or `err[i]` is high.
- R12: While a channel is busy, writes to its control or count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the request pins are sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_addr | input | 2 | Register select: 0 control, 1 byte count, 2 status |
| wr_data | input | DW | Write data |
| dreq | input | NCH | External request pin per channel |
| bus_grant | input | 1 | Bus unit accepts the presented request |
| cyc_done | input | 1 | Bus unit finished the granted operand |
| xfer_req | output | 1 | Transfer request to the bus unit |
| xfer_ch | output | CH_W | Channel behind `xfer_req` |
| xfer_size | output | 2 | Operand size code of the selected channel |
| busy | output | NCH | Channel running |
| done | output | NCH | Channel byte count exhausted |
| err | output | NCH | Channel start rejected for a bad setup |
| irq | output | NCH | Interrupt per channel |

## Verification
The bench builds the block with two channels, a 16-bit write port and a 16-bit byte count. Two channels are the fewest that can show priority, pre-grant takeover and the hold of a granted operand against a higher-priority request. Byte counts of 0 to 8 are enough to reach every alignment and multiple-of-size rejection, as well as the zero-count case. They also let burst and cycle-steal runs finish within a few operands, so the exact operand count before `done` is observed.

// File: rtl/dmarq_pkg.sv
`timescale 1ns/1ps
package dmarq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } opsize_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  localparam int CB_START = 0;
  localparam int CB_BURST = 1;
  localparam int CB_SZ_LO = 2;
  localparam int CB_SRC0  = 4;
  localparam int CB_DST0  = 5;

  localparam int SB_DONE = 0;
  localparam int SB_ERR  = 1;

  function automatic logic [2:0] size_bytes(input opsize_e s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmarq_sync.sv
`timescale 1ns/1ps
module dmarq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] st1_q;
  logic [W-1:0] st2_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= din;
      st2_q <= st1_q;
    end
  end

  assign dout = st2_q;

endmodule

// File: rtl/dmarq_chan.sv
`timescale 1ns/1ps
module dmarq_chan
  import dmarq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          dreq_s,
  input  logic          op_done,
  output logic          req,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    size
);

  localparam int PADW = CNT_W - 3;

  logic             busy_q, done_q, err_q, burst_q, pend_q, prev_q;
  opsize_e          size_q;
  logic [CNT_W-1:0] cnt_q;

  opsize_e          w_size;
  logic             wr_ctrl, wr_cnt, wr_stat, start;
  logic             align_bad, count_bad, cfg_bad;
  logic [CNT_W-1:0] step;
  logic             last_op, rise, rise_run;

  assign w_size  = opsize_e'(wr_data[CB_SZ_LO+1:CB_SZ_LO]);
  assign wr_ctrl = wr_sel && (wr_addr == A_CTRL) && !busy_q;
  assign wr_cnt  = wr_sel && (wr_addr == A_COUNT) && !busy_q;
  assign wr_stat = wr_sel && (wr_addr == A_STAT);
  assign start   = wr_ctrl && wr_data[CB_START];

  assign align_bad = (w_size != SZ_BYTE) && (wr_data[CB_SRC0] || wr_data[CB_DST0]);

  always_comb begin
    case (w_size)
      SZ_BYTE: count_bad = 1'b0;
      SZ_WORD: count_bad = cnt_q[0];
      SZ_LONG: count_bad = |cnt_q[1:0];
      default: count_bad = 1'b1;
    endcase
    if (cnt_q == '0) count_bad = 1'b1;
  end

  assign cfg_bad  = align_bad || count_bad;
  assign step     = {{PADW{1'b0}}, size_bytes(size_q)};
  assign last_op  = (cnt_q == step);
  assign rise     = dreq_s && !prev_q;
  assign rise_run = rise && busy_q && !burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      burst_q <= 1'b0;
      pend_q  <= 1'b0;
      prev_q  <= 1'b0;
      size_q  <= SZ_BYTE;
      cnt_q   <= '0;
    end else begin
      prev_q <= dreq_s;

      if (wr_stat) begin
        if (wr_data[SB_DONE]) done_q <= 1'b0;
        if (wr_data[SB_ERR])  err_q  <= 1'b0;
      end

      if (wr_cnt) cnt_q <= wr_data[CNT_W-1:0];

      if (wr_ctrl) begin
        burst_q <= wr_data[CB_BURST];
        size_q  <= w_size;
      end

      if (start) begin
        if (cfg_bad) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          pend_q <= dreq_s && !wr_data[CB_BURST];
        end
      end else if (op_done) begin
        cnt_q  <= cnt_q - step;
        pend_q <= rise_run;
        if (last_op) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pend_q <= 1'b0;
        end
      end else if (rise_run) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign req  = busy_q && (burst_q ? dreq_s : (pend_q || rise));
  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign size = size_q;

endmodule

// File: rtl/dmarq_arb.sv
`timescale 1ns/1ps
module dmarq_arb #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  req,
  input  logic            bus_grant,
  input  logic            cyc_done,
  output logic            xfer_req,
  output logic [CH_W-1:0] xfer_ch,
  output logic [NCH-1:0]  op_done
);

  logic            req_q, lock_q;
  logic [CH_W-1:0] ch_q, pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      lock_q <= 1'b0;
      ch_q   <= '0;
    end else if (lock_q) begin
      if (cyc_done) begin
        lock_q <= 1'b0;
        req_q  <= 1'b0;
      end
    end else if (req_q && bus_grant) begin
      lock_q <= 1'b1;
    end else begin
      req_q <= |req;
      ch_q  <= pick;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_done
    assign op_done[g] = lock_q && cyc_done && (ch_q == CH_W'(g));
  end

  assign xfer_req = req_q;
  assign xfer_ch  = ch_q;

endmodule

// File: rtl/dma_req_seq.sv
`timescale 1ns/1ps
module dma_req_seq #(
  parameter int NCH   = 2,
  parameter int DW    = 16,
  parameter int CNT_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  dreq,
  input  logic            bus_grant,
  input  logic            cyc_done,
  output logic            xfer_req,
  output logic [CH_W-1:0] xfer_ch,
  output logic [1:0]      xfer_size,
  output logic [NCH-1:0]  busy,
  output logic [NCH-1:0]  done,
  output logic [NCH-1:0]  err,
  output logic [NCH-1:0]  irq
);

  logic [NCH-1:0] dreq_s, chan_req, op_done;
  logic [1:0]     size_v [NCH];

  dmarq_sync #(.W(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (dreq),
    .dout(dreq_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmarq_chan #(.DW(DW), .CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_sel (wr_en && (wr_ch == CH_W'(g))),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .dreq_s (dreq_s[g]),
      .op_done(op_done[g]),
      .req    (chan_req[g]),
      .busy   (busy[g]),
      .done   (done[g]),
      .err    (err[g]),
      .size   (size_v[g])
    );
  end

  dmarq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (chan_req),
    .bus_grant(bus_grant),
    .cyc_done (cyc_done),
    .xfer_req (xfer_req),
    .xfer_ch  (xfer_ch),
    .op_done  (op_done)
  );

  assign xfer_size = size_v[xfer_ch];
  assign irq       = done | err;

endmodule

// File: rtl/dmarq_chk.sv
`timescale 1ns/1ps
module dmarq_chk #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_grant,
  input logic            cyc_done,
  input logic            xfer_req,
  input logic [CH_W-1:0] xfer_ch,
  input logic [NCH-1:0]  busy,
  input logic [NCH-1:0]  done,
  input logic [NCH-1:0]  err
);

  logic held;

  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else if (held && cyc_done) held <= 1'b0;
    else if (xfer_req && bus_grant) held <= 1'b1;
  end

  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    held && !cyc_done |=> xfer_req && $stable(xfer_ch)); // R9

  AST_GAP_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
    held && cyc_done |=> !xfer_req); // R9

  AST_REQ_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> busy[xfer_ch]); // R3

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      $rose(err[g]) |-> !busy[g]); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      $rose(done[g]) |-> $fell(busy[g])); // R10
  end

endmodule

bind dma_req_seq dmarq_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_grant(bus_grant),
  .cyc_done (cyc_done),
  .xfer_req (xfer_req),
  .xfer_ch  (xfer_ch),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/dma_req_seq_tb.sv
`timescale 1ns/1ps
module dma_req_seq_tb;

  logic        clk = 1'b0;
  logic        rst, wr_en, wr_ch, bus_grant, cyc_done;
  logic [1:0]  wr_addr, dreq, xfer_size, busy, done, err, irq;
  logic [15:0] wr_data;
  logic        xfer_req, xfer_ch;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_req_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .dreq(dreq), .bus_grant(bus_grant), .cyc_done(cyc_done),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch), .xfer_size(xfer_size),
    .busy(busy), .done(done), .err(err), .irq(irq)
  );

  // {size[1:0], src0, dst0, expect_err, count[15:0]}
  localparam logic [20:0] VEC [10] = '{
    {2'd0, 1'b1, 1'b1, 1'b0, 16'd3},
    {2'd1, 1'b1, 1'b0, 1'b1, 16'd4},
    {2'd1, 1'b0, 1'b1, 1'b1, 16'd4},
    {2'd1, 1'b0, 1'b0, 1'b0, 16'd6},
    {2'd1, 1'b0, 1'b0, 1'b1, 16'd5},
    {2'd2, 1'b0, 1'b0, 1'b0, 16'd8},
    {2'd2, 1'b0, 1'b0, 1'b1, 16'd6},
    {2'd2, 1'b0, 1'b1, 1'b1, 16'd8},
    {2'd3, 1'b0, 1'b0, 1'b1, 16'd4},
    {2'd0, 1'b0, 1'b0, 1'b1, 16'd0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; dreq = '0; bus_grant = 1'b0; cyc_done = 1'b0; wr_en = 1'b0;
    wr_ch = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic start_ch(input logic ch, input logic bst, input logic [1:0] sz,
                          input logic s0, input logic d0, input logic [15:0] cnt);
    wr(ch, 2'd1, cnt);
    wr(ch, 2'd0, {10'd0, d0, s0, sz, bst, 1'b1});
  endtask

  task automatic serve();
    bus_grant = 1'b1;
    tick(1);
    bus_grant = 1'b0;
    tick(1);
    chk("R9 request held during operand", {31'd0, xfer_req}, 32'd1);
    cyc_done = 1'b1;
    tick(1);
    cyc_done = 1'b0;
    chk("R9 request low after operand", {31'd0, xfer_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; dreq = '0; bus_grant = 1'b0; cyc_done = 1'b0; wr_en = 1'b0;
    wr_ch = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    chk("R1 reset flags", {22'd0, xfer_req, busy, done, err, irq}, 32'd0);
    rst = 1'b0;
    tick(2);
    chk("R1 after release", {22'd0, xfer_req, busy, done, err, irq}, 32'd0);

    // R6 R7: setup checking table
    for (int v = 0; v < 10; v++) begin
      do_reset();
      start_ch(1'b0, 1'b0, VEC[v][20:19], VEC[v][18], VEC[v][17], VEC[v][15:0]);
      chk($sformatf("R6 R7 vector %0d err", v), {31'd0, err[0]}, {31'd0, VEC[v][16]});
      chk($sformatf("R6 R7 vector %0d busy", v), {31'd0, busy[0]}, {31'd0, !VEC[v][16]});
    end

    // R2 R5 R10: burst byte run of 3
    do_reset();
    start_ch(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'd3);
    tick(2);
    chk("R5 no burst request without dreq", {31'd0, xfer_req}, 32'd0);
    dreq[0] = 1'b1;
    tick(1);
    chk("R2 not yet after one edge", {31'd0, xfer_req}, 32'd0);
    tick(1);
    chk("R2 request after sync", {29'd0, xfer_req, xfer_ch, xfer_size[0]}, 32'b100);
    serve();
    tick(1);
    chk("R5 second burst operand", {31'd0, xfer_req}, 32'd1);
    serve();
    tick(1);
    chk("R5 third burst operand", {31'd0, xfer_req}, 32'd1);
    serve();
    chk("R10 done after count", {28'd0, done[0], busy[0], irq[0], 1'b0}, 32'b1010);
    tick(3);
    chk("R5 no request after count end", {31'd0, xfer_req}, 32'd0);

    // R5 R12: dreq dropped stops burst, writes while busy ignored
    do_reset();
    start_ch(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'd8);
    dreq[0] = 1'b1;
    tick(2);
    chk("R5 burst request", {31'd0, xfer_req}, 32'd1);
    dreq[0] = 1'b0;
    serve();
    tick(3);
    chk("R5 stopped by low dreq", {29'd0, xfer_req, busy[0], done[0]}, 32'b010);
    wr(1'b0, 2'd1, 16'd2);
    wr(1'b0, 2'd0, {10'd0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1});
    dreq[0] = 1'b1;
    tick(2);
    chk("R12 size unchanged while busy", {30'd0, xfer_size}, 32'd0);
    for (int k = 0; k < 7; k++) begin
      if (k > 0) tick(1);
      chk("R12 count unchanged while busy", {31'd0, xfer_req}, 32'd1);
      serve();
    end
    chk("R12 R10 done after remaining 7", {30'd0, done[0], busy[0]}, 32'b10);

    // R10: word and longword steps
    do_reset();
    start_ch(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 16'd6);
    dreq[1] = 1'b1;
    tick(2);
    chk("R10 word size shown", {29'd0, xfer_ch, xfer_size}, 32'b101);
    serve();
    tick(1);
    serve();
    chk("R10 word not done after 4 bytes", {30'd0, done[1], busy[1]}, 32'b01);
    tick(1);
    serve();
    chk("R10 word done after 6 bytes", {30'd0, done[1], busy[1]}, 32'b10);
    do_reset();
    start_ch(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 16'd8);
    dreq[0] = 1'b1;
    tick(2);
    serve();
    chk("R10 long not done after 4 bytes", {30'd0, done[0], busy[0]}, 32'b01);
    tick(1);
    serve();
    chk("R10 long done after 8 bytes", {30'd0, done[0], busy[0]}, 32'b10);

    // R3 R4: cycle-steal
    do_reset();
    dreq[1] = 1'b1;
    tick(4);
    chk("R3 ignored before start", {31'd0, xfer_req}, 32'd0);
    start_ch(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'd2);
    chk("R4 not yet at start edge", {31'd0, xfer_req}, 32'd0);
    tick(1);
    chk("R4 internal request", {30'd0, xfer_req, xfer_ch}, 32'b11);
    serve();
    tick(3);
    chk("R3 held level gives one operand", {31'd0, xfer_req}, 32'd0);
    dreq[1] = 1'b0;
    tick(3);
    dreq[1] = 1'b1;
    tick(1);
    chk("R2 cycle-steal not yet", {31'd0, xfer_req}, 32'd0);
    tick(1);
    chk("R3 new edge new operand", {30'd0, xfer_req, xfer_ch}, 32'b11);
    serve();
    chk("R10 cycle-steal done", {31'd0, done[1]}, 32'd1);

    // R8 R9: priority, takeover before grant, hold after grant
    do_reset();
    start_ch(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd4);
    start_ch(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'd4);
    dreq = 2'b11;
    tick(2);
    chk("R8 channel 0 first", {30'd0, xfer_req, xfer_ch}, 32'b10);
    serve();
    tick(1);
    chk("R8 channel 1 next", {30'd0, xfer_req, xfer_ch}, 32'b11);
    serve();
    dreq = 2'b00;
    tick(3);
    dreq[1] = 1'b1;
    tick(2);
    chk("R8 lone channel 1", {30'd0, xfer_req, xfer_ch}, 32'b11);
    dreq[0] = 1'b1;
    tick(2);
    chk("R8 takeover before grant", {30'd0, xfer_req, xfer_ch}, 32'b10);
    serve();
    tick(1);
    chk("R8 channel 1 after takeover", {30'd0, xfer_req, xfer_ch}, 32'b11);
    bus_grant = 1'b1;
    tick(1);
    bus_grant = 1'b0;
    dreq[0] = 1'b0;
    tick(3);
    dreq[0] = 1'b1;
    tick(3);
    chk("R9 granted operand kept", {30'd0, xfer_req, xfer_ch}, 32'b11);
    cyc_done = 1'b1;
    tick(1);
    cyc_done = 1'b0;
    chk("R9 gap cycle", {31'd0, xfer_req}, 32'd0);
    tick(1);
    chk("R9 R8 waiting channel 0 served", {30'd0, xfer_req, xfer_ch}, 32'b10);
    serve();

    // R11: status clearing
    do_reset();
    start_ch(1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 16'd4);
    chk("R11 irq from err", {30'd0, err[0], irq[0]}, 32'b11);
    wr(1'b0, 2'd2, 16'd1);
    chk("R11 done bit leaves err", {30'd0, err[0], irq[0]}, 32'b11);
    wr(1'b0, 2'd2, 16'd2);
    chk("R11 err cleared", {30'd0, err[0], irq[0]}, 32'b00);
    start_ch(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 16'd1);
    dreq[1] = 1'b1;
    tick(2);
    serve();
    chk("R11 irq from done", {30'd0, done[1], irq[1]}, 32'b11);
    wr(1'b1, 2'd2, 16'd2);
    chk("R11 err bit leaves done", {31'd0, done[1]}, 32'd1);
    wr(1'b1, 2'd2, 16'd1);
    chk("R11 done cleared", {30'd0, done[1], irq[1]}, 32'b00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule